// File: doc/BRIEF.md
# Segmented Selector Address Translator

This block turns a logical address into a 32-bit physical address. A logical address is a 16-bit selector plus a 32-bit effective offset. The selector names a descriptor in one of two in-memory tables. One is the global table, whose base and limit sit in a register loaded through `gtab_wr`. The other is the local table, whose base and limit are held in a cache. The block fetches the 8-byte descriptor one byte per acknowledged read and checks both the table limit and the segment limit. It then returns either `segment base + offset` or a fault code.

A write to the local-table selector (`lsel_wr`) reloads the local cache by itself. The block uses the selector's index to read a descriptor from the global table and keeps its base and limit. Requests and results use a valid/ready handshake. A request that arrives while a reload is pending or running is held off until the reload is finished, so it always sees the new local table. Privilege checks and access-rights rules are out of scope. The two access bytes are only passed back.

The controller has four states:
- `ST_IDLE` accepts a pending reload first, then a request.
- `ST_FETCH` reads descriptor bytes.
- `ST_EVAL` either fills the local cache or forms the result.
- `ST_RESP` holds the result until `rsp_ready`.

It has these transitions:
- IDLE→FETCH when a request or reload passes its table check.
- IDLE→RESP when a request fails its table check.
- IDLE→IDLE when a reload fails its table check.
- FETCH→EVAL on the acknowledge of the last byte.
- EVAL→IDLE after a reload.
- EVAL→RESP after a translation.
- RESP→IDLE on `rsp_ready`.

Top module: `seg_xlate`

## Requirements
- R1: Selector bits 15:3 are the descriptor index and bit 2 picks the table (0 global, 1 local). Bits 1:0 have no effect on the result.
- R2: Descriptor bytes are read from `table base + index*8 + k`, for k counting up from 0, one byte per cycle in which `mem_ack` is high. `mem_rd` and `mem_addr` stay stable until the acknowledge. A translation reads 8 bytes.
- R3: Descriptor bytes 0-3 are the segment base and bytes 4-5 are the segment limit, both little-endian. Bytes 6-7 come back on `rsp_access` (byte 6 in bits 7:0) whenever the descriptor was fetched.
- R4: If `index*8+7` is greater than the chosen table's limit, the result is `rsp_fault`=01 with `rsp_addr`=0 and `rsp_access`=0, and no memory read is made.
- R5: If the offset is greater than the segment limit, the result is `rsp_fault`=10 with `rsp_addr`=0. An offset equal to the limit is legal. Code 11 never appears.
- R6: With no fault, `rsp_fault`=00 and `rsp_addr` = segment base + offset, modulo 2^32.
- R7: A local-selector write reloads the local cache from global descriptor `index`: 6 bytes are read, giving the base from bytes 0-3 and the limit from bytes 4-5. The written value's bits 2:0 are ignored.
- R8: A reload whose index fails the global table-limit check marks the local cache invalid. Every local request then gives `rsp_fault`=01 until a later reload succeeds.
- R9: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is low while a result waits. The result stays stable while `rsp_valid` is high and `rsp_ready` is low.
- R10: `busy` is high from an accepted request or a selector write until the result is handed over or the reload ends. A request arriving during a reload waits and uses the reloaded table.
- R11: After reset, `busy`, `rsp_valid` and `mem_rd` are low and `req_ready` is high. Both table limits are 0, the global base is 0 and the local cache is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gtab_wr | input | 1 | Load the global table base and limit |
| gtab_base | input | 32 | Global table base address |
| gtab_limit | input | 16 | Global table limit |
| lsel_wr | input | 1 | Write the local-table selector and start a reload |
| lsel_data | input | 16 | Local-table selector value |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request can be taken |
| req_sel | input | 16 | Request selector |
| req_off | input | 32 | Request effective offset |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result taken by the consumer |
| rsp_addr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 table limit, 10 segment limit |
| rsp_access | output | 16 | Access bytes 6-7 of the descriptor |
| busy | output | 1 | Fetch, reload or result in progress |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_ack | input | 1 | Read acknowledge, data valid this cycle |
| mem_rdata | input | 8 | Read data byte |

## Verification
A wrong byte counter or descriptor base shows up straight away on `mem_addr` during the fetch. It also shows in the first result after it, as a wrong base or limit in the returned address. A stale or wrongly kept local cache state is invisible until the next local request. That request then returns the old table's segment or a wrong table fault, so each reload in the bench is followed at once by a local translation. Checking that a fault skipped memory comes from counting the bytes read per request. A lost pending-reload flag would let a waiting request through with the previous table, and that shows in that request's own result.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int PA_W       = 32;
    localparam int SEL_W      = 16;
    localparam int LIM_W      = 16;
    localparam int DESC_BYTES = 8;
    localparam int IDX_W      = SEL_W - 3;
    localparam int CNT_W      = $clog2(DESC_BYTES);

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_TABLE   = 2'b01,
        FLT_SEGMENT = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EVAL,
        ST_RESP
    } state_e;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
    parameter int PA_W  = seg_xlate_pkg::PA_W,
    parameter int LIM_W = seg_xlate_pkg::LIM_W,
    parameter int IDX_W = seg_xlate_pkg::IDX_W
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             ti,
    input  logic             force_global,
    input  logic [PA_W-1:0]  gbase,
    input  logic [LIM_W-1:0] glim,
    input  logic [PA_W-1:0]  lbase,
    input  logic [LIM_W-1:0] llim,
    input  logic             lvalid,
    output logic [PA_W-1:0]  desc_addr,
    output logic             tab_fault
);
    localparam int SPAN_W = IDX_W + 3;

    logic             use_local;
    logic [PA_W-1:0]  tbase;
    logic [LIM_W-1:0] tlim;
    logic [SPAN_W-1:0] last_byte;

    always_comb begin
        use_local = ti && !force_global;
        tbase     = use_local ? lbase : gbase;
        tlim      = use_local ? llim  : glim;
        last_byte = {idx, 3'b111};
        tab_fault = (last_byte > tlim) || (use_local && !lvalid);
        desc_addr = tbase + {{(PA_W-SPAN_W){1'b0}}, idx, 3'b000};
    end
endmodule

// File: rtl/seg_desc_collect.sv
module seg_desc_collect #(
    parameter int N_BYTES = seg_xlate_pkg::DESC_BYTES,
    parameter int IDX_W   = $clog2(N_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     byte_idx,
    input  logic [7:0]           byte_in,
    output logic [N_BYTES*8-1:0] desc_out
);
    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && byte_idx == IDX_W'(b))
                q <= byte_in;
        end
        assign desc_out[b*8 +: 8] = q;
    end
endmodule

// File: rtl/seg_limit_add.sv
module seg_limit_add #(
    parameter int PA_W  = seg_xlate_pkg::PA_W,
    parameter int LIM_W = seg_xlate_pkg::LIM_W
) (
    input  logic [PA_W-1:0]  seg_base,
    input  logic [LIM_W-1:0] seg_limit,
    input  logic [PA_W-1:0]  offset,
    output logic [PA_W-1:0]  phys,
    output logic             seg_fault
);
    always_comb begin
        seg_fault = offset > {{(PA_W-LIM_W){1'b0}}, seg_limit};
        phys      = seg_base + offset;
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = PA_W,
    parameter int LIMW   = LIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gtab_wr,
    input  logic [ADDR_W-1:0] gtab_base,
    input  logic [LIMW-1:0]   gtab_limit,
    input  logic              lsel_wr,
    input  logic [SEL_W-1:0]  lsel_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [ADDR_W-1:0] req_off,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [1:0]        rsp_fault,
    output logic [15:0]       rsp_access,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata
);
    localparam logic [CNT_W-1:0] LAST_XLATE  = CNT_W'(DESC_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_RELOAD = CNT_W'(5);

    state_e state_q, state_d;

    logic [ADDR_W-1:0] gdt_base_q, ldt_base_q, dbase_q, off_q;
    logic [LIMW-1:0]   gdt_lim_q, ldt_lim_q;
    logic              ldt_ok_q, reload_pend_q, op_reload_q;
    logic [IDX_W-1:0]  lsel_idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] rsp_addr_q;
    fault_e            rsp_fault_q;
    logic [15:0]       rsp_acc_q;

    logic [IDX_W-1:0]  dec_idx;
    logic [ADDR_W-1:0] desc_addr;
    logic              tab_fault, seg_fault, req_fire, byte_done, last_byte;
    logic [DESC_BYTES*8-1:0] desc;
    logic [ADDR_W-1:0] phys;
    logic              unused_bits;

    assign unused_bits = ^{req_sel[1:0], lsel_data[2:0]};
    assign dec_idx     = reload_pend_q ? lsel_idx_q : req_sel[SEL_W-1:3];
    assign req_fire    = req_valid && req_ready;
    assign byte_done   = (state_q == ST_FETCH) && mem_ack;
    assign last_byte   = cnt_q == (op_reload_q ? LAST_RELOAD : LAST_XLATE);

    seg_sel_decode #(.PA_W(ADDR_W), .LIM_W(LIMW), .IDX_W(IDX_W)) u_decode (
        .idx(dec_idx), .ti(req_sel[2]), .force_global(reload_pend_q),
        .gbase(gdt_base_q), .glim(gdt_lim_q),
        .lbase(ldt_base_q), .llim(ldt_lim_q), .lvalid(ldt_ok_q),
        .desc_addr(desc_addr), .tab_fault(tab_fault)
    );

    seg_desc_collect #(.N_BYTES(DESC_BYTES), .IDX_W(CNT_W)) u_collect (
        .clk(clk), .rst_n(rst_n), .wr_en(byte_done), .byte_idx(cnt_q),
        .byte_in(mem_rdata), .desc_out(desc)
    );

    seg_limit_add #(.PA_W(ADDR_W), .LIM_W(LIMW)) u_limit (
        .seg_base(desc[31:0]), .seg_limit(desc[47:32]), .offset(off_q),
        .phys(phys), .seg_fault(seg_fault)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (reload_pend_q)
                    state_d = tab_fault ? ST_IDLE : ST_FETCH;
                else if (req_fire)
                    state_d = tab_fault ? ST_RESP : ST_FETCH;
            end
            ST_FETCH: if (mem_ack && last_byte) state_d = ST_EVAL;
            ST_EVAL:  state_d = op_reload_q ? ST_IDLE : ST_RESP;
            ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE) && !reload_pend_q && !lsel_wr;
        busy       = (state_q != ST_IDLE) || reload_pend_q;
        mem_rd     = (state_q == ST_FETCH);
        mem_addr   = dbase_q + {{(ADDR_W-CNT_W){1'b0}}, cnt_q};
        rsp_valid  = (state_q == ST_RESP);
        rsp_addr   = rsp_addr_q;
        rsp_fault  = rsp_fault_q;
        rsp_access = rsp_acc_q;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gdt_base_q    <= '0;
            gdt_lim_q     <= '0;
            ldt_base_q    <= '0;
            ldt_lim_q     <= '0;
            ldt_ok_q      <= 1'b0;
            lsel_idx_q    <= '0;
            reload_pend_q <= 1'b0;
            op_reload_q   <= 1'b0;
            cnt_q         <= '0;
            dbase_q       <= '0;
            off_q         <= '0;
            rsp_addr_q    <= '0;
            rsp_fault_q   <= FLT_NONE;
            rsp_acc_q     <= '0;
        end else begin
            if (gtab_wr) begin
                gdt_base_q <= gtab_base;
                gdt_lim_q  <= gtab_limit;
            end
            if (lsel_wr) begin
                lsel_idx_q    <= lsel_data[SEL_W-1:3];
                reload_pend_q <= 1'b1;
            end else if (state_q == ST_IDLE && reload_pend_q) begin
                reload_pend_q <= 1'b0;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (reload_pend_q) begin
                        op_reload_q <= 1'b1;
                        cnt_q       <= '0;
                        dbase_q     <= desc_addr;
                        if (tab_fault) ldt_ok_q <= 1'b0;
                    end else if (req_fire) begin
                        op_reload_q <= 1'b0;
                        cnt_q       <= '0;
                        dbase_q     <= desc_addr;
                        off_q       <= req_off;
                        if (tab_fault) begin
                            rsp_fault_q <= FLT_TABLE;
                            rsp_addr_q  <= '0;
                            rsp_acc_q   <= '0;
                        end
                    end
                end
                ST_FETCH: if (mem_ack) cnt_q <= cnt_q + 1'b1;
                ST_EVAL: begin
                    if (op_reload_q) begin
                        ldt_base_q <= desc[31:0];
                        ldt_lim_q  <= desc[47:32];
                        ldt_ok_q   <= 1'b1;
                    end else begin
                        rsp_fault_q <= seg_fault ? FLT_SEGMENT : FLT_NONE;
                        rsp_addr_q  <= seg_fault ? '0 : phys;
                        rsp_acc_q   <= desc[63:48];
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        busy,
    input logic        mem_rd,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_addr,
    input logic [1:0]  rsp_fault,
    input logic [15:0] rsp_access
);
    AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault) && $stable(rsp_access)); // R9
    AST_NO_READY_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R9
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 2'b00 |-> rsp_addr == 32'h0); // R4
    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault != 2'b11); // R5
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !mem_ack |=> mem_rd && $stable(mem_addr)); // R2
    AST_MEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && mem_ack |=> !mem_rd || mem_addr == $past(mem_addr) + 32'd1); // R2
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> busy); // R10
    AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy); // R10
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .busy(busy), .mem_rd(mem_rd), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_fault(rsp_fault), .rsp_access(rsp_access)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gtab_wr = 1'b0;
    logic [31:0] gtab_base = '0;
    logic [15:0] gtab_limit = '0;
    logic        lsel_wr = 1'b0;
    logic [15:0] lsel_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_sel = '0;
    logic [31:0] req_off = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_fault;
    logic [15:0] rsp_access;
    logic        busy, mem_rd, mem_ack;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata;

    logic [7:0]  mem [0:4095];
    int          checks = 0;
    int          fails = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_first = '0;

    logic [49:0] exp_q [$];   // {addr, fault, access}
    string       tag_q [$];

    always #2.5 clk = ~clk;

    assign mem_ack   = mem_rd;
    assign mem_rdata = mem[mem_addr[11:0]];

    seg_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .gtab_wr(gtab_wr), .gtab_base(gtab_base),
        .gtab_limit(gtab_limit), .lsel_wr(lsel_wr), .lsel_data(lsel_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
        .req_off(req_off), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_fault(rsp_fault), .rsp_access(rsp_access),
        .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic put_desc(input int at, input logic [31:0] base, input logic [15:0] lim, input logic [15:0] acc);
        for (int k = 0; k < 4; k++) mem[at+k] = base[k*8 +: 8];
        mem[at+4] = lim[7:0];
        mem[at+5] = lim[15:8];
        mem[at+6] = acc[7:0];
        mem[at+7] = acc[15:8];
    endtask

    // monitor: compare each handed-over result against the scoreboard
    always @(negedge clk) begin
        if (mem_rd && mem_ack) begin
            if (rd_cnt == 0) rd_first = mem_addr;
            rd_cnt++;
        end
        if (rst_n && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected result", {30'b0, rsp_fault, rsp_addr}, 64'h0);
            end else begin
                logic [49:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({rsp_addr, rsp_fault, rsp_access} == e, t,
                      {14'b0, rsp_addr, rsp_fault, rsp_access}, {14'b0, e});
            end
        end
    end

    task automatic xlate(input logic [15:0] sel, input logic [31:0] off, input logic [31:0] ea,
                         input logic [1:0] ef, input logic [15:0] eacc, input string t);
        exp_q.push_back({ea, ef, eacc});
        tag_q.push_back(t);
        req_sel   = sel;
        req_off   = off;
        req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic lsel_write(input logic [15:0] v);
        lsel_data = v;
        lsel_wr   = 1'b1;
        @(posedge clk); #1;
        lsel_wr   = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        // global table at 0x100, 8 entries
        put_desc(32'h100 + 1*8, 32'h0005_0000, 16'h00FF, 16'h0082);
        put_desc(32'h100 + 2*8, 32'h0010_0000, 16'h0FFF, 16'h0093);
        put_desc(32'h100 + 5*8, 32'h0000_0400, 16'h001F, 16'h0082);
        put_desc(32'h100 + 6*8, 32'h0000_0600, 16'h000F, 16'h0082);
        // local table A at 0x400
        put_desc(32'h400 + 1*8, 32'h0020_0000, 16'h001F, 16'h1234);
        put_desc(32'h400 + 3*8, 32'hFFFF_FFF0, 16'hFFFF, 16'h00F2);
        // local table B at 0x600
        put_desc(32'h600 + 1*8, 32'h0030_0000, 16'h00FF, 16'h5555);

        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !rsp_valid && !mem_rd && req_ready, "R11 reset outputs",
              {60'b0, busy, rsp_valid, mem_rd, req_ready}, 64'h1);
        @(posedge clk); #1;

        // R11/R4: global limit is 0 after reset
        xlate(16'h0000, 32'h0, 32'h0, 2'b01, 16'h0, "R11 R4 global limit zero at reset");
        // R8: local cache invalid after reset
        xlate(16'h000C, 32'h0, 32'h0, 2'b01, 16'h0, "R8 local cache invalid at reset");
        drain();

        gtab_base = 32'h100; gtab_limit = 16'h003F; gtab_wr = 1'b1;
        @(posedge clk); #1 gtab_wr = 1'b0;

        // R1 R2 R3 R6: plain global translation, privilege bits set
        rd_cnt = 0;
        xlate(16'h0013, 32'h10, 32'h0010_0010, 2'b00, 16'h0093, "R1 R3 R6 global index 2");
        drain();
        check(rd_cnt == 8, "R2 bytes read per translation", rd_cnt, 8);
        check(rd_first == 32'h110, "R2 descriptor address", rd_first, 32'h110);

        // R5 boundaries
        xlate(16'h0010, 32'h0FFF, 32'h0010_0FFF, 2'b00, 16'h0093, "R5 offset equal to limit");
        xlate(16'h0010, 32'h1000, 32'h0, 2'b10, 16'h0093, "R5 offset past limit");
        drain();

        // R4: table limit, no memory read
        rd_cnt = 0;
        xlate(16'h0040, 32'h0, 32'h0, 2'b01, 16'h0, "R4 global index 8 past table");
        drain();
        check(rd_cnt == 0, "R4 no read on table fault", rd_cnt, 0);
        xlate(16'h003B, 32'h0, 32'h0, 2'b00, 16'h0, "R4 last entry in table");
        drain();

        // R7 R10: reload then request waits for it
        rd_cnt = 0;
        lsel_write(16'h002F);
        check(busy && !req_ready, "R10 busy after selector write",
              {62'b0, busy, req_ready}, 64'h2);
        xlate(16'h000F, 32'h10, 32'h0020_0010, 2'b00, 16'h1234, "R7 R10 local after reload");
        drain();
        check(rd_cnt == 14, "R7 reload reads 6 bytes", rd_cnt, 14);

        // R6 wrap, R4 local limit, R1 table bit
        xlate(16'h001C, 32'h20, 32'h0000_0010, 2'b00, 16'h00F2, "R6 address wraps");
        xlate(16'h0024, 32'h0, 32'h0, 2'b01, 16'h0, "R4 local index past local limit");
        xlate(16'h000B, 32'h4, 32'h0005_0004, 2'b00, 16'h0082, "R1 table bit 0 picks global");
        xlate(16'h000C, 32'h4, 32'h0020_0004, 2'b00, 16'h1234, "R1 table bit 1 picks local");
        drain();

        // R7: switch to second local table
        lsel_write(16'h0030);
        xlate(16'h000C, 32'h80, 32'h0030_0080, 2'b00, 16'h5555, "R7 second local table");
        drain();

        // R9: backpressure
        rsp_ready = 1'b0;
        xlate(16'h0010, 32'h44, 32'h0010_0044, 2'b00, 16'h0093, "R9 result after hold");
        repeat (14) @(posedge clk);
        @(negedge clk);
        check(rsp_valid && !req_ready && busy, "R9 result held under backpressure",
              {61'b0, rsp_valid, req_ready, busy}, 64'h5);
        @(posedge clk); #1 rsp_ready = 1'b1;
        drain();

        // R8: failed reload invalidates, good reload restores
        lsel_write(16'h0050);
        xlate(16'h000C, 32'h0, 32'h0, 2'b01, 16'h0, "R8 local after failed reload");
        drain();
        lsel_write(16'h0028);
        xlate(16'h000C, 32'h1, 32'h0020_0001, 2'b00, 16'h1234, "R8 local after good reload");
        drain();

        check(exp_q.size() == 0, "R9 all results delivered", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule